// File: doc/BRIEF.md
# Round-Robin Arbiter for AXI4-Lite Masters

This block lets several AXI4-Lite masters share a single AXI4-Lite slave port. Writes and reads are arbitrated on their own, so each direction has its own owner. A master makes a write request by raising its address-valid or its data-valid. A read request is a raised read-address-valid. When a direction is free, the arbiter takes an owner in the next clock cycle. It then connects only that master's channels to the slave until the slave's response for that transaction has been handed over.

Response data and response codes go to every master port. Only the owner sees a ready or a response-valid. At release, the next owner is found by a circular search that starts at the master that just finished. A master that keeps requesting with no gap therefore runs all of its transfers in a row. A master that pauses for one cycle gives its turn to the next master above it that is waiting.

Top module: `axil_rr_arbiter`

## Requirements
- R1: Synchronous active-high reset frees both directions. While reset is high, no slave-side valid and no master-side ready or response-valid is raised, even when masters are requesting.
- R2: In any cycle at most one master sees address-ready, write-data-ready or write-response-valid. At most one master sees read-address-ready or read-data-valid. Every master that does not own the direction sees these signals low.
- R3: A write request is address-valid OR data-valid. The owner's address, data and byte strobes reach the slave unchanged. The slave's 2-bit write response code (00 = OKAY, 10 = error) reaches the owner.
- R4: A read request is read-address-valid. The owner's read address reaches the slave, and the slave's read data and 2-bit response code reach that master.
- R5: Ownership of a direction does not change from the moment it is granted until the response handshake (valid and ready both high) on that direction, however many cycles the slave waits. Other requesting masters get no ready and no response during that time.
- R6: A direction is released in the cycle after its response handshake. If the previous owner is requesting in that free cycle, it is granted again. Back-to-back masters are therefore served in batches: master 0 for all its transfers, then master 1, then master 2.
- R7: If the previous owner is idle in the free cycle, the grant goes to the first requesting master in increasing index order, wrapping from the highest index to 0. After reset the search starts at master 0. Masters that pause one cycle between transfers are served in the order 0, 1, 2, 0, 1, 2, and so on.
- R8: Write and read arbitration do not depend on each other. A read can be in flight on the slave port while a write is in flight.
- R9: A free direction becomes owned exactly one cycle after a request appears, and the request is forwarded to the slave in that cycle. A free direction with no request stays free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_awaddr | input | NM*AW | Write addresses, master i in slice i |
| m_awvalid | input | NM | Write address valid per master |
| m_awready | output | NM | Write address ready per master |
| m_wdata | input | NM*DW | Write data per master |
| m_wstrb | input | NM*DW/8 | Byte strobes per master |
| m_wvalid | input | NM | Write data valid per master |
| m_wready | output | NM | Write data ready per master |
| m_bresp | output | NM*2 | Write response code, copied to every master |
| m_bvalid | output | NM | Write response valid per master |
| m_bready | input | NM | Write response ready per master |
| m_araddr | input | NM*AW | Read addresses per master |
| m_arvalid | input | NM | Read address valid per master |
| m_arready | output | NM | Read address ready per master |
| m_rdata | output | NM*DW | Read data, copied to every master |
| m_rresp | output | NM*2 | Read response code, copied to every master |
| m_rvalid | output | NM | Read data valid per master |
| m_rready | input | NM | Read data ready per master |
| s_awaddr | output | AW | Slave write address |
| s_awvalid | output | 1 | Slave write address valid |
| s_awready | input | 1 | Slave write address ready |
| s_wdata | output | DW | Slave write data |
| s_wstrb | output | DW/8 | Slave byte strobes |
| s_wvalid | output | 1 | Slave write data valid |
| s_wready | input | 1 | Slave write data ready |
| s_bresp | input | 2 | Slave write response code |
| s_bvalid | input | 1 | Slave write response valid |
| s_bready | output | 1 | Slave write response ready |
| s_araddr | output | AW | Slave read address |
| s_arvalid | output | 1 | Slave read address valid |
| s_arready | input | 1 | Slave read address ready |
| s_rdata | input | DW | Slave read data |
| s_rresp | input | 2 | Slave read response code |
| s_rvalid | input | 1 | Slave read data valid |
| s_rready | output | 1 | Slave read data ready |

## Verification
The assertions rely on these input rules:
- The slave raises a response-valid only after it has accepted the matching address, and for writes only after it has also accepted the data.
- Each master has at most one transaction open per direction.
- Each master keeps its valids high until the matching handshake.

The bench slave model follows these rules. It lowers its ready once it has accepted an address or data beat. It answers only after a configurable delay that starts once the transaction is complete. The bench masters issue a new transaction only after the previous response has been taken.

// File: rtl/axl_arb_pkg.sv
package axl_arb_pkg;

    localparam int RESP_W = 2;
    localparam logic [RESP_W-1:0] RESP_OKAY = 2'b00;

    typedef enum logic {
        GS_FREE = 1'b0,
        GS_HELD = 1'b1
    } grant_state_e;

    // true when master idx currently owns a direction
    function automatic logic owns(input logic held, input int owner, input int idx);
        return held && (owner == idx);
    endfunction

endpackage

// File: rtl/axl_rr_pick.sv
module axl_rr_pick #(
    parameter int N  = 3,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] pick
);

    // circular search beginning at start itself (start wins if requesting)
    always_comb begin
        found = 1'b0;
        pick  = start;
        for (int k = 0; k < N; k++) begin
            if (!found && req[(int'(start) + k) % N]) begin
                found = 1'b1;
                pick  = IW'((int'(start) + k) % N);
            end
        end
    end

endmodule

// File: rtl/axl_grant.sv
module axl_grant
    import axl_arb_pkg::*;
#(
    parameter int N  = 3,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          done,
    output logic          held,
    output logic [IW-1:0] owner
);

    grant_state_e  state;
    logic          found;
    logic [IW-1:0] pick;

    axl_rr_pick #(.N(N), .IW(IW)) u_pick (
        .req   (req),
        .start (owner),
        .found (found),
        .pick  (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GS_FREE;
            owner <= '0;
        end else begin
            case (state)
                GS_FREE: begin
                    if (found) begin
                        state <= GS_HELD;
                        owner <= pick;
                    end
                end
                GS_HELD: begin
                    if (done) state <= GS_FREE;
                end
                default: state <= GS_FREE;
            endcase
        end
    end

    assign held = (state == GS_HELD);

endmodule

// File: rtl/axil_rr_arbiter.sv
module axil_rr_arbiter
    import axl_arb_pkg::*;
#(
    parameter int NM = 3,
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NM*AW-1:0]       m_awaddr,
    input  logic [NM-1:0]          m_awvalid,
    output logic [NM-1:0]          m_awready,
    input  logic [NM*DW-1:0]       m_wdata,
    input  logic [NM*(DW/8)-1:0]   m_wstrb,
    input  logic [NM-1:0]          m_wvalid,
    output logic [NM-1:0]          m_wready,
    output logic [NM*RESP_W-1:0]   m_bresp,
    output logic [NM-1:0]          m_bvalid,
    input  logic [NM-1:0]          m_bready,
    input  logic [NM*AW-1:0]       m_araddr,
    input  logic [NM-1:0]          m_arvalid,
    output logic [NM-1:0]          m_arready,
    output logic [NM*DW-1:0]       m_rdata,
    output logic [NM*RESP_W-1:0]   m_rresp,
    output logic [NM-1:0]          m_rvalid,
    input  logic [NM-1:0]          m_rready,
    output logic [AW-1:0]          s_awaddr,
    output logic                   s_awvalid,
    input  logic                   s_awready,
    output logic [DW-1:0]          s_wdata,
    output logic [DW/8-1:0]        s_wstrb,
    output logic                   s_wvalid,
    input  logic                   s_wready,
    input  logic [RESP_W-1:0]      s_bresp,
    input  logic                   s_bvalid,
    output logic                   s_bready,
    output logic [AW-1:0]          s_araddr,
    output logic                   s_arvalid,
    input  logic                   s_arready,
    input  logic [DW-1:0]          s_rdata,
    input  logic [RESP_W-1:0]      s_rresp,
    input  logic                   s_rvalid,
    output logic                   s_rready
);

    localparam int IW = (NM > 1) ? $clog2(NM) : 1;
    localparam int SW = DW / 8;

    logic          wr_held, rd_held;
    logic [IW-1:0] wr_owner, rd_owner;
    logic [NM-1:0] wr_req, rd_req;
    logic          wr_done, rd_done;

    assign wr_req  = m_awvalid | m_wvalid;
    assign rd_req  = m_arvalid;
    assign wr_done = s_bvalid & s_bready;
    assign rd_done = s_rvalid & s_rready;

    axl_grant #(.N(NM), .IW(IW)) u_wr_grant (
        .clk   (clk),
        .rst   (rst),
        .req   (wr_req),
        .done  (wr_done),
        .held  (wr_held),
        .owner (wr_owner)
    );

    axl_grant #(.N(NM), .IW(IW)) u_rd_grant (
        .clk   (clk),
        .rst   (rst),
        .req   (rd_req),
        .done  (rd_done),
        .held  (rd_held),
        .owner (rd_owner)
    );

    // master-to-slave request muxes
    always_comb begin
        s_awaddr  = m_awaddr[int'(wr_owner)*AW +: AW];
        s_wdata   = m_wdata[int'(wr_owner)*DW +: DW];
        s_wstrb   = m_wstrb[int'(wr_owner)*SW +: SW];
        s_awvalid = wr_held & m_awvalid[wr_owner];
        s_wvalid  = wr_held & m_wvalid[wr_owner];
        s_bready  = wr_held & m_bready[wr_owner];
        s_araddr  = m_araddr[int'(rd_owner)*AW +: AW];
        s_arvalid = rd_held & m_arvalid[rd_owner];
        s_rready  = rd_held & m_rready[rd_owner];
    end

    // slave-to-master: payload broadcast, handshakes gated per owner
    for (genvar g = 0; g < NM; g++) begin : g_port
        logic wsel, rsel;
        assign wsel = owns(wr_held, int'(wr_owner), g);
        assign rsel = owns(rd_held, int'(rd_owner), g);

        assign m_awready[g] = wsel & s_awready;
        assign m_wready[g]  = wsel & s_wready;
        assign m_bvalid[g]  = wsel & s_bvalid;
        assign m_bresp[g*RESP_W +: RESP_W] = s_bresp;

        assign m_arready[g] = rsel & s_arready;
        assign m_rvalid[g]  = rsel & s_rvalid;
        assign m_rdata[g*DW +: DW] = s_rdata;
        assign m_rresp[g*RESP_W +: RESP_W] = s_rresp;
    end

endmodule

// File: rtl/axil_rr_arbiter_chk.sv
module axil_rr_arbiter_chk #(
    parameter int NM = 3,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [NM-1:0] m_awvalid,
    input logic [NM-1:0] m_wvalid,
    input logic [NM-1:0] m_arvalid,
    input logic [NM-1:0] m_awready,
    input logic [NM-1:0] m_wready,
    input logic [NM-1:0] m_bvalid,
    input logic [NM-1:0] m_arready,
    input logic [NM-1:0] m_rvalid,
    input logic          s_bvalid,
    input logic          s_bready,
    input logic          s_rvalid,
    input logic          s_rready,
    input logic          wr_held,
    input logic [IW-1:0] wr_owner,
    input logic          rd_held,
    input logic [IW-1:0] rd_owner
);

    p_reset_free_r1: assert property (@(posedge clk)
        rst |=> !wr_held && !rd_held);

    p_one_wr_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_awready) && $onehot0(m_wready) && $onehot0(m_bvalid));

    p_one_rd_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_arready) && $onehot0(m_rvalid));

    p_wr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        wr_held && !(s_bvalid && s_bready) |=> wr_held && $stable(wr_owner));

    p_rd_hold_r5: assert property (@(posedge clk) disable iff (rst)
        rd_held && !(s_rvalid && s_rready) |=> rd_held && $stable(rd_owner));

    p_wr_release_r6: assert property (@(posedge clk) disable iff (rst)
        wr_held && s_bvalid && s_bready |=> !wr_held);

    p_rd_release_r6: assert property (@(posedge clk) disable iff (rst)
        rd_held && s_rvalid && s_rready |=> !rd_held);

    p_wr_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_held && (m_awvalid[wr_owner] || m_wvalid[wr_owner]) |=> wr_held && $stable(wr_owner));

    p_rd_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_held && m_arvalid[rd_owner] |=> rd_held && $stable(rd_owner));

    p_wr_grant_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_held && (|(m_awvalid | m_wvalid)) |=> wr_held);

    p_wr_noreq_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_held && !(|(m_awvalid | m_wvalid)) |=> !wr_held);

    p_rd_noreq_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_held && !(|m_arvalid) |=> !rd_held);

endmodule

bind axil_rr_arbiter axil_rr_arbiter_chk #(.NM(NM), .IW(IW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .m_awvalid (m_awvalid),
    .m_wvalid  (m_wvalid),
    .m_arvalid (m_arvalid),
    .m_awready (m_awready),
    .m_wready  (m_wready),
    .m_bvalid  (m_bvalid),
    .m_arready (m_arready),
    .m_rvalid  (m_rvalid),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .wr_held   (wr_held),
    .wr_owner  (wr_owner),
    .rd_held   (rd_held),
    .rd_owner  (rd_owner)
);

// File: tb/axil_rr_arbiter_tb.sv
module axil_rr_arbiter_tb;

    localparam int NM = 3;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;
    localparam int K  = 4;
    localparam int NT = NM * K;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NM*AW-1:0] m_awaddr, m_araddr;
    logic [NM-1:0]    m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
    logic [NM-1:0]    m_arvalid, m_arready, m_rvalid, m_rready;
    logic [NM*DW-1:0] m_wdata, m_rdata;
    logic [NM*SW-1:0] m_wstrb;
    logic [NM*2-1:0]  m_bresp, m_rresp;
    logic [AW-1:0]    s_awaddr, s_araddr;
    logic             s_awvalid, s_awready, s_wvalid, s_wready, s_bvalid, s_bready;
    logic             s_arvalid, s_arready, s_rvalid, s_rready;
    logic [DW-1:0]    s_wdata, s_rdata;
    logic [SW-1:0]    s_wstrb;
    logic [1:0]       s_bresp, s_rresp;

    axil_rr_arbiter #(.NM(NM), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst),
        .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- expected-value rules ----------------
    function automatic logic [1:0] exp_bresp(input logic [AW-1:0] a);
        return (a == 101) ? 2'b10 : 2'b00;
    endfunction
    function automatic logic [1:0] exp_rresp(input logic [AW-1:0] a);
        return (a == 202) ? 2'b10 : 2'b00;
    endfunction
    function automatic logic [DW-1:0] exp_rdata(input logic [AW-1:0] a);
        return DW'(a) ^ DW'(32'h5A5A0000);
    endfunction
    function automatic logic [DW-1:0] exp_wdata(input logic [AW-1:0] a);
        return DW'(a * 3 + 7);
    endfunction
    function automatic logic [SW-1:0] exp_strb(input int i);
        return {SW{1'b1}} ^ SW'(i);
    endfunction

    // ---------------- model state ----------------
    int gap_v, lat_v;
    int wk[NM], rk[NM], wgap[NM], rgap[NM];
    bit wbusy[NM], rbusy[NM];
    logic [AW-1:0] wcur[NM], rcur[NM];
    bit fl_aw[NM], fl_w[NM], fl_b[NM], fl_ar[NM], fl_r[NM];
    logic [1:0] cb[NM], cr[NM];
    logic [DW-1:0] crd[NM];

    bit have_aw, have_w, have_ar;
    int blat, rlat, wown, rown;
    logic [AW-1:0] aw_q, ar_q, cap_aw, cap_ar;
    logic [DW-1:0] w_q, cap_w;
    logic [SW-1:0] st_q, cap_st;
    bit sl_aw, sl_w, sl_b, sl_ar, sl_r;

    logic [AW-1:0] wl_a[NT], rl_a[NT];
    logic [DW-1:0] wl_d[NT];
    logic [SW-1:0] wl_s[NT];
    int wn, rn;
    int bresp_bad, rdata_bad, r2_bad, excl_bad, overlap;

    task automatic clear_model();
        for (int i = 0; i < NM; i++) begin
            wk[i] = 0; rk[i] = 0; wgap[i] = 0; rgap[i] = 0;
            wbusy[i] = 0; rbusy[i] = 0; wcur[i] = '0; rcur[i] = '0;
            fl_aw[i] = 0; fl_w[i] = 0; fl_b[i] = 0; fl_ar[i] = 0; fl_r[i] = 0;
        end
        have_aw = 0; have_w = 0; have_ar = 0; blat = 0; rlat = 0; wown = 0; rown = 0;
        sl_aw = 0; sl_w = 0; sl_b = 0; sl_ar = 0; sl_r = 0;
        wn = 0; rn = 0; bresp_bad = 0; rdata_bad = 0; r2_bad = 0; excl_bad = 0; overlap = 0;
        m_awvalid = '0; m_wvalid = '0; m_arvalid = '0;
        m_awaddr = '0; m_araddr = '0; m_wdata = '0; m_wstrb = '0;
        s_awready = 1'b1; s_wready = 1'b1; s_arready = 1'b1;
        s_bvalid = 1'b0; s_rvalid = 1'b0; s_bresp = '0; s_rresp = '0; s_rdata = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        clear_model();
        m_awvalid = '1; m_wvalid = '1; m_arvalid = '1;
        repeat (3) @(negedge clk);
        #4;
        // R1: requests during reset must not reach anything
        check(!s_awvalid && !s_wvalid && !s_arvalid && !s_bready && !s_rready,
              "R1 slave side quiet", {s_awvalid, s_wvalid, s_arvalid, s_bready, s_rready}, 0);
        check(m_awready == 0 && m_wready == 0 && m_arready == 0,
              "R1 master ready low", {m_awready, m_wready, m_arready}, 0);
        @(negedge clk);
        m_awvalid = '0; m_wvalid = '0; m_arvalid = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step_apply();
        // slave write side
        if (sl_aw) begin have_aw = 1; aw_q = cap_aw; wown = int'(cap_aw) / 100; end
        if (sl_w)  begin have_w = 1; w_q = cap_w; st_q = cap_st; end
        if (sl_b) begin
            if (wn < NT) begin wl_a[wn] = aw_q; wl_d[wn] = w_q; wl_s[wn] = st_q; end
            wn++;
            have_aw = 0; have_w = 0; s_bvalid = 0; blat = 0;
        end
        if (have_aw && have_w && !s_bvalid) begin
            if (blat >= lat_v) begin s_bvalid = 1; s_bresp = exp_bresp(aw_q); end
            else blat++;
        end
        s_awready = !have_aw;
        s_wready  = !have_w;
        // slave read side
        if (sl_ar) begin have_ar = 1; ar_q = cap_ar; rown = int'(cap_ar) / 100; end
        if (sl_r) begin
            if (rn < NT) rl_a[rn] = ar_q;
            rn++;
            have_ar = 0; s_rvalid = 0; rlat = 0;
        end
        if (have_ar && !s_rvalid) begin
            if (rlat >= lat_v) begin
                s_rvalid = 1; s_rdata = exp_rdata(ar_q); s_rresp = exp_rresp(ar_q);
            end else rlat++;
        end
        s_arready = !have_ar;
        // masters
        for (int i = 0; i < NM; i++) begin
            if (fl_aw[i]) m_awvalid[i] = 1'b0;
            if (fl_w[i])  m_wvalid[i]  = 1'b0;
            if (fl_b[i]) begin
                if (cb[i] != exp_bresp(wcur[i])) bresp_bad++;
                wbusy[i] = 0; wgap[i] = gap_v;
            end
            if (!wbusy[i] && wk[i] < K) begin
                if (wgap[i] > 0) wgap[i]--;
                else begin
                    wcur[i] = AW'(i * 100 + wk[i]);
                    m_awaddr[i*AW +: AW] = wcur[i];
                    m_wdata[i*DW +: DW]  = exp_wdata(wcur[i]);
                    m_wstrb[i*SW +: SW]  = exp_strb(i);
                    m_awvalid[i] = 1'b1; m_wvalid[i] = 1'b1;
                    wbusy[i] = 1; wk[i]++;
                end
            end
            if (fl_ar[i]) m_arvalid[i] = 1'b0;
            if (fl_r[i]) begin
                if (crd[i] != exp_rdata(rcur[i]) || cr[i] != exp_rresp(rcur[i])) rdata_bad++;
                rbusy[i] = 0; rgap[i] = gap_v;
            end
            if (!rbusy[i] && rk[i] < K) begin
                if (rgap[i] > 0) rgap[i]--;
                else begin
                    rcur[i] = AW'(i * 100 + rk[i]);
                    m_araddr[i*AW +: AW] = rcur[i];
                    m_arvalid[i] = 1'b1;
                    rbusy[i] = 1; rk[i]++;
                end
            end
        end
    endtask

    task automatic step_sample();
        for (int i = 0; i < NM; i++) begin
            fl_aw[i] = m_awvalid[i] && m_awready[i];
            fl_w[i]  = m_wvalid[i] && m_wready[i];
            fl_b[i]  = m_bvalid[i];
            cb[i]    = m_bresp[i*2 +: 2];
            fl_ar[i] = m_arvalid[i] && m_arready[i];
            fl_r[i]  = m_rvalid[i];
            cr[i]    = m_rresp[i*2 +: 2];
            crd[i]   = m_rdata[i*DW +: DW];
        end
        sl_aw = s_awvalid && s_awready; cap_aw = s_awaddr;
        sl_w  = s_wvalid && s_wready;   cap_w = s_wdata; cap_st = s_wstrb;
        sl_b  = s_bvalid && s_bready;
        sl_ar = s_arvalid && s_arready; cap_ar = s_araddr;
        sl_r  = s_rvalid && s_rready;
        if ($countones(m_awready) > 1 || $countones(m_wready) > 1 || $countones(m_bvalid) > 1 ||
            $countones(m_arready) > 1 || $countones(m_rvalid) > 1) r2_bad++;
        for (int j = 0; j < NM; j++) begin
            if (have_aw && j != wown && (m_awready[j] || m_wready[j] || m_bvalid[j])) excl_bad++;
            if (have_ar && j != rown && (m_arready[j] || m_rvalid[j])) excl_bad++;
        end
        if ((s_awvalid || s_wvalid || s_bvalid) && (s_arvalid || s_rvalid)) overlap++;
    endtask

    function automatic bit all_done();
        for (int i = 0; i < NM; i++)
            if (wk[i] < K || rk[i] < K || wbusy[i] || rbusy[i]) return 0;
        return 1;
    endfunction

    task automatic run_scenario(input int gap, input int lat, input bit rotate, input string ordtag);
        int cyc;
        do_reset();
        gap_v = gap; lat_v = lat;
        cyc = 0;
        while (!all_done() && cyc < 3000) begin
            @(negedge clk);
            step_apply();
            #4;
            step_sample();
            cyc++;
        end
        check(wn == NT, "R3 write count", wn, NT);
        check(rn == NT, "R4 read count", rn, NT);
        for (int j = 0; j < NT && j < wn; j++) begin
            int e;
            e = rotate ? ((j % NM) * 100 + j / NM) : ((j / K) * 100 + j % K);
            check(wl_a[j] == AW'(e), {ordtag, " write order"}, wl_a[j], e);
            check(wl_d[j] == exp_wdata(wl_a[j]) && wl_s[j] == exp_strb(int'(wl_a[j]) / 100),
                  "R3 data/strobe", {wl_d[j], wl_s[j]}, {exp_wdata(wl_a[j]), exp_strb(int'(wl_a[j]) / 100)});
        end
        for (int j = 0; j < NT && j < rn; j++) begin
            int e;
            e = rotate ? ((j % NM) * 100 + j / NM) : ((j / K) * 100 + j % K);
            check(rl_a[j] == AW'(e), {ordtag, " R4 read order"}, rl_a[j], e);
        end
        check(bresp_bad == 0, "R3 write response code", bresp_bad, 0);
        check(rdata_bad == 0, "R4 read data/code", rdata_bad, 0);
        check(r2_bad == 0, "R2 single owner", r2_bad, 0);
        check(excl_bad == 0, "R5 held owner exclusive", excl_bad, 0);
    endtask

    initial begin
        m_bready = '1;
        m_rready = '1;
        clear_model();
        gap_v = 0; lat_v = 0;

        // R9 / R7: lone request on master 2 right after reset
        do_reset();
        @(negedge clk);
        m_awaddr[2*AW +: AW] = AW'(77);
        m_awvalid[2] = 1'b1;
        m_wvalid[2]  = 1'b1;
        #4;
        check(s_awvalid == 1'b0, "R9 not forwarded before grant", s_awvalid, 0);
        @(negedge clk);
        #4;
        check(s_awvalid == 1'b1 && s_awaddr == AW'(77), "R9 R7 forwarded after one cycle",
              {s_awvalid, s_awaddr}, {1'b1, AW'(77)});
        check(m_awready == 3'b100, "R2 only owner ready", m_awready, 3'b100);
        check(s_arvalid == 1'b0, "R9 idle read stays free", s_arvalid, 0);

        run_scenario(0, 0, 1'b0, "R6");
        check(overlap > 0, "R8 read and write concurrent", overlap, 1);
        run_scenario(1, 0, 1'b1, "R7");
        run_scenario(0, 3, 1'b0, "R5 R6");
        run_scenario(1, 3, 1'b1, "R5 R7");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule